// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Sequencer

This block is a single DMA channel that runs a linked program of 16-byte command descriptors kept in memory. Software places the descriptors, then pulses `start` with the address of the first one. The channel reads each descriptor and decodes its command halfword. It then does one of three things: moves data between memory and a device stream port in either direction, performs a single-word load or store, or does nothing. Afterwards it writes the leftover byte count and a status halfword back into the descriptor.

Each descriptor carries three 2-bit condition codes, tested against a device condition input that is sampled when the command finishes. They control a branch to an address held in the descriptor, a one-cycle interrupt pulse, and a hold that keeps the channel from fetching its next descriptor until the condition input drops. A stop command ends the program. A malformed descriptor halts the channel and flags it dead.

The memory port carries one request at a time. `mem_req` stays high with stable address, write-enable and data until `mem_ack`, and read data arrives alongside `mem_ack`. On the stream ports, a word moves on a clock edge where both valid and ready are high.

Top module: `dma_desc_chan`

## Requirements
- R1: After reset, `active`, `dead`, `irq`, `mem_req`, `dev_tx_valid` and `dev_rx_ready` are all low.
- R2: A `start` pulse while the channel is idle makes the channel fetch the descriptor words at offsets 0, 4 and 8. Word 0 holds the byte count in bits 15:0 and the command in bits 31:16. Within the command halfword, bits 15:12 are the opcode, 10:8 the key, 5:4 the interrupt code, 3:2 the branch code and 1:0 the wait code. Word 1 is the data address and word 2 the branch target.
- R3: Opcodes 0 and 1 read memory words at consecutive addresses starting at the data address and emit them on the transmit port, one word per 4 bytes of count (rounded up). `dev_tx_last` is high only on the final word, and only for opcode 1.
- R4: Opcodes 2 and 3 accept receive words and write them to consecutive addresses, each word consuming up to 4 bytes of count. Under opcode 3, a word received with `dev_rx_last` high ends the command early. Under opcode 2, `dev_rx_last` is ignored.
- R5: Every command except stop ends by writing to descriptor offset 12. The low half of the written word is the residual byte count. The high half is the status: bit 15 set, bit 1 = branch taken, bit 0 = the condition sampled at completion, all other bits zero.
- R6: Opcode 4 writes descriptor word 2 to the data address. Opcode 5 reads the data address and writes the value to descriptor offset 8. The branch target is still the word 2 fetched before the load.
- R7: Opcodes 4, 5 and 6 move no stream data, and their residual equals the request count. Opcode 6 makes no memory access apart from the fetch and the write-back.
- R8: Branch code 0 is never, 1 if the condition is high, 2 if it is low, and 3 always. When the branch is taken, the next descriptor is at word 2; otherwise it is at the current address plus 16.
- R9: The interrupt code uses the same encoding as the branch code. When it is satisfied, `irq` pulses high for exactly one cycle after the write-back.
- R10: When the wait code (same encoding) is satisfied, no further descriptor is fetched until `dev_cond` is low.
- R11: Opcode 7 clears `active` without writing back and leaves `dead` low.
- R12: A key of 4, an opcode above 7, or a count above 0x8000 sets `dead`, clears `active` and skips the write-back. A count of exactly 0x8000 is accepted. A new `start` clears `dead`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a program (sampled when idle) |
| start_addr | input | AW | Address of the first descriptor |
| active | output | 1 | Channel is running a program |
| dead | output | 1 | Channel halted on a malformed descriptor |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| dev_key | output | 3 | Key of the current command |
| dev_tx_valid | output | 1 | Transmit word valid |
| dev_tx_data | output | 32 | Transmit word |
| dev_tx_last | output | 1 | Final word of an output-last command |
| dev_tx_ready | input | 1 | Device accepts transmit word |
| dev_rx_valid | input | 1 | Receive word valid |
| dev_rx_data | input | 32 | Receive word |
| dev_rx_last | input | 1 | Receive word ends the packet |
| dev_rx_ready | output | 1 | Channel accepts receive word |
| dev_cond | input | 1 | Device condition input |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest state to reach from the ports is the wait hold. The channel must already have written one descriptor's status yet still be parked in front of the next one. That happens only if the condition input stays high across command completion and afterwards. The bench therefore holds `dev_cond` high through a wait-always command and lets many cycles pass. It then checks that the first status word has been written while the second descriptor's marker word is unchanged and the channel is still active. Finally it drops the condition and confirms that the program runs to its end.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int DESC_BYTES = 16;

  localparam logic [3:0] OP_OUT_MORE = 4'd0;
  localparam logic [3:0] OP_OUT_LAST = 4'd1;
  localparam logic [3:0] OP_IN_MORE  = 4'd2;
  localparam logic [3:0] OP_IN_LAST  = 4'd3;
  localparam logic [3:0] OP_STORE_Q  = 4'd4;
  localparam logic [3:0] OP_LOAD_Q   = 4'd5;
  localparam logic [3:0] OP_NOP      = 4'd6;
  localparam logic [3:0] OP_STOP     = 4'd7;

  localparam logic [2:0] KEY_RESERVED = 3'd4;

  localparam logic [1:0] CC_NEVER = 2'd0;
  localparam logic [1:0] CC_HIGH  = 2'd1;
  localparam logic [1:0] CC_LOW   = 2'd2;
  localparam logic [1:0] CC_ALL   = 2'd3;

  typedef struct packed {
    logic [3:0] op;
    logic [2:0] key;
    logic [1:0] irq_cc;
    logic [1:0] br_cc;
    logic [1:0] wt_cc;
  } cmd_t;
endpackage

// File: rtl/dma_desc_decode.sv
module dma_desc_decode
  import dma_desc_pkg::*;
#(
  parameter int MAX_COUNT = 32'h8000
) (
  input  logic [WORD_W-1:0] word0,
  output cmd_t              cmd,
  output logic [15:0]       count,
  output logic              bad
);
  logic [15:0] chw;
  logic        unused_rsv;

  assign chw         = word0[31:16];
  assign count       = word0[15:0];
  assign cmd.op      = chw[15:12];
  assign cmd.key     = chw[10:8];
  assign cmd.irq_cc  = chw[5:4];
  assign cmd.br_cc   = chw[3:2];
  assign cmd.wt_cc   = chw[1:0];
  assign unused_rsv  = ^{chw[11], chw[7:6]};

  always_comb begin
    bad = 1'b0;
    if (cmd.key == KEY_RESERVED) bad = 1'b1;
    if (cmd.op[3]) bad = 1'b1;
    if ({16'b0, count} > 32'(MAX_COUNT)) bad = 1'b1;
  end
endmodule

// File: rtl/dma_cond_eval.sv
module dma_cond_eval
  import dma_desc_pkg::*;
(
  input  logic [1:0] code,
  input  logic       cond,
  output logic       hit
);
  always_comb begin
    case (code)
      CC_NEVER: hit = 1'b0;
      CC_HIGH:  hit = cond;
      CC_LOW:   hit = ~cond;
      default:  hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/dma_beat_count.sv
module dma_beat_count #(
  parameter int AW    = 32,
  parameter int CNT_W = 16,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic [AW-1:0]    load_addr,
  input  logic             step,
  output logic [CNT_W-1:0] rem,
  output logic [AW-1:0]    addr,
  output logic             zero,
  output logic             last
);
  localparam logic [CNT_W-1:0] STEP_C = CNT_W'(STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      addr <= '0;
    end else if (load) begin
      rem  <= load_cnt;
      addr <= load_addr;
    end else if (step) begin
      addr <= addr + AW'(STEP);
      rem  <= (rem >= STEP_C) ? rem - STEP_C : '0;
    end
  end

  assign zero = (rem == '0);
  assign last = !zero && (rem <= STEP_C);

  p_rem_down_r4: assert property (@(posedge clk) disable iff (rst)
    !load |=> rem <= $past(rem));
  p_step_live_r3: assert property (@(posedge clk) disable iff (rst)
    step |-> !zero);
endmodule

// File: rtl/dma_desc_chan.sv
module dma_desc_chan
  import dma_desc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CNT_W     = 16,
  parameter int MAX_COUNT = 32'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  output logic              active,
  output logic              dead,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [2:0]        dev_key,
  output logic              dev_tx_valid,
  output logic [WORD_W-1:0] dev_tx_data,
  output logic              dev_tx_last,
  input  logic              dev_tx_ready,
  input  logic              dev_rx_valid,
  input  logic [WORD_W-1:0] dev_rx_data,
  input  logic              dev_rx_last,
  output logic              dev_rx_ready,
  input  logic              dev_cond,
  output logic              irq
);
  localparam int          N_COND   = 3;
  localparam logic [AW-1:0] DESC_STEP = AW'(DESC_BYTES);
  localparam logic [AW-1:0] OFS_W2    = AW'(2 * WORD_BYTES);
  localparam logic [AW-1:0] OFS_W3    = AW'(3 * WORD_BYTES);

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_CHECK, S_OUT_RD, S_TX, S_RX, S_IN_WR,
    S_QST, S_QLD_RD, S_QLD_WR, S_WB, S_POST, S_WAIT
  } state_e;

  state_e            st;
  logic [AW-1:0]     desc_ptr;
  logic [1:0]        word_idx;
  logic [WORD_W-1:0] w0_q, w1_q, w2_q, hold_q;
  logic              cond_q;
  logic              early_q;

  cmd_t              cmd;
  logic [15:0]       req_cnt;
  logic              bad;

  logic              bc_load, bc_step, bc_zero, bc_last;
  logic [CNT_W-1:0]  bc_rem;
  logic [AW-1:0]     bc_addr;

  logic [1:0]        cc_code [N_COND];
  logic [N_COND-1:0] cc_hit;
  logic              irq_hit, br_hit, wt_hit;
  logic [15:0]       status_hw;
  logic              mem_done;

  dma_desc_decode #(.MAX_COUNT(MAX_COUNT)) u_decode (
    .word0 (w0_q),
    .cmd   (cmd),
    .count (req_cnt),
    .bad   (bad)
  );

  assign cc_code[0] = cmd.irq_cc;
  assign cc_code[1] = cmd.br_cc;
  assign cc_code[2] = cmd.wt_cc;

  generate
    for (genvar gi = 0; gi < N_COND; gi++) begin : g_cond
      dma_cond_eval u_eval (
        .code (cc_code[gi]),
        .cond (cond_q),
        .hit  (cc_hit[gi])
      );
    end
  endgenerate

  assign irq_hit = cc_hit[0];
  assign br_hit  = cc_hit[1];
  assign wt_hit  = cc_hit[2];

  assign mem_done = mem_req && mem_ack;
  assign bc_load  = (st == S_CHECK);
  assign bc_step  = ((st == S_TX) && dev_tx_valid && dev_tx_ready) ||
                    ((st == S_IN_WR) && mem_done);

  dma_beat_count #(.AW(AW), .CNT_W(CNT_W), .STEP(WORD_BYTES)) u_beats (
    .clk       (clk),
    .rst       (rst),
    .load      (bc_load),
    .load_cnt  (CNT_W'(req_cnt)),
    .load_addr (w1_q[AW-1:0]),
    .step      (bc_step),
    .rem       (bc_rem),
    .addr      (bc_addr),
    .zero      (bc_zero),
    .last      (bc_last)
  );

  assign status_hw = {1'b1, 13'b0, br_hit, cond_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      desc_ptr     <= '0;
      word_idx     <= '0;
      w0_q         <= '0;
      w1_q         <= '0;
      w2_q         <= '0;
      hold_q       <= '0;
      cond_q       <= 1'b0;
      early_q      <= 1'b0;
      active       <= 1'b0;
      dead         <= 1'b0;
      mem_req      <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      dev_key      <= '0;
      dev_tx_valid <= 1'b0;
      dev_tx_data  <= '0;
      dev_tx_last  <= 1'b0;
      dev_rx_ready <= 1'b0;
      irq          <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            desc_ptr <= start_addr;
            word_idx <= '0;
            active   <= 1'b1;
            dead     <= 1'b0;
            st       <= S_FETCH;
          end
        end

        S_FETCH: begin
          if (mem_done) begin
            mem_req <= 1'b0;
            case (word_idx)
              2'd0:    w0_q <= mem_rdata;
              2'd1:    w1_q <= mem_rdata;
              default: w2_q <= mem_rdata;
            endcase
            if (word_idx == 2'd2) st <= S_CHECK;
            else word_idx <= word_idx + 2'd1;
          end else if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= desc_ptr + AW'({word_idx, 2'b00});
          end
        end

        S_CHECK: begin
          early_q <= 1'b0;
          dev_key <= cmd.key;
          if (bad) begin
            dead   <= 1'b1;
            active <= 1'b0;
            st     <= S_IDLE;
          end else begin
            case (cmd.op)
              OP_OUT_MORE, OP_OUT_LAST: st <= S_OUT_RD;
              OP_IN_MORE, OP_IN_LAST:   st <= S_RX;
              OP_STORE_Q:               st <= S_QST;
              OP_LOAD_Q:                st <= S_QLD_RD;
              OP_NOP: begin
                cond_q <= dev_cond;
                st     <= S_WB;
              end
              default: begin
                active <= 1'b0;
                st     <= S_IDLE;
              end
            endcase
          end
        end

        S_OUT_RD: begin
          if (mem_done) begin
            mem_req      <= 1'b0;
            dev_tx_data  <= mem_rdata;
            dev_tx_valid <= 1'b1;
            dev_tx_last  <= (cmd.op == OP_OUT_LAST) && bc_last;
            st           <= S_TX;
          end else if (!mem_req) begin
            if (bc_zero) begin
              cond_q <= dev_cond;
              st     <= S_WB;
            end else begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= bc_addr;
            end
          end
        end

        S_TX: begin
          if (dev_tx_ready) begin
            dev_tx_valid <= 1'b0;
            dev_tx_last  <= 1'b0;
            st           <= S_OUT_RD;
          end
        end

        S_RX: begin
          if (dev_rx_ready && dev_rx_valid) begin
            dev_rx_ready <= 1'b0;
            hold_q       <= dev_rx_data;
            early_q      <= (cmd.op == OP_IN_LAST) && dev_rx_last;
            st           <= S_IN_WR;
          end else if (bc_zero || early_q) begin
            dev_rx_ready <= 1'b0;
            cond_q       <= dev_cond;
            st           <= S_WB;
          end else begin
            dev_rx_ready <= 1'b1;
          end
        end

        S_IN_WR: begin
          if (mem_done) begin
            mem_req <= 1'b0;
            st      <= S_RX;
          end else if (!mem_req) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= bc_addr;
            mem_wdata <= hold_q;
          end
        end

        S_QST: begin
          if (mem_done) begin
            mem_req <= 1'b0;
            cond_q  <= dev_cond;
            st      <= S_WB;
          end else if (!mem_req) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= bc_addr;
            mem_wdata <= w2_q;
          end
        end

        S_QLD_RD: begin
          if (mem_done) begin
            mem_req <= 1'b0;
            hold_q  <= mem_rdata;
            st      <= S_QLD_WR;
          end else if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= bc_addr;
          end
        end

        S_QLD_WR: begin
          if (mem_done) begin
            mem_req <= 1'b0;
            cond_q  <= dev_cond;
            st      <= S_WB;
          end else if (!mem_req) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= desc_ptr + OFS_W2;
            mem_wdata <= hold_q;
          end
        end

        S_WB: begin
          if (mem_done) begin
            mem_req <= 1'b0;
            st      <= S_POST;
          end else if (!mem_req) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= desc_ptr + OFS_W3;
            mem_wdata <= {status_hw, 16'(bc_rem)};
          end
        end

        S_POST: begin
          irq      <= irq_hit;
          desc_ptr <= br_hit ? w2_q[AW-1:0] : desc_ptr + DESC_STEP;
          word_idx <= '0;
          st       <= wt_hit ? S_WAIT : S_FETCH;
        end

        S_WAIT: begin
          if (!dev_cond) st <= S_FETCH;
        end

        default: st <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  p_dead_halted_r12: assert property (@(posedge clk) disable iff (rst)
    dead |-> !active);
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (rst)
    dev_tx_valid && !dev_tx_ready |=> dev_tx_valid && $stable(dev_tx_data));
  p_last_final_r3: assert property (@(posedge clk) disable iff (rst)
    dev_tx_valid && dev_tx_last |-> bc_last);
  p_no_fetch_waiting_r10: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT) |-> !mem_req);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !active |-> !dev_tx_valid && !dev_rx_ready);
endmodule

// File: tb/test_dma_desc_chan.sv
`timescale 1ns/1ps
module test_dma_desc_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic        active, dead, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [2:0]  dev_key;
  logic        dev_tx_valid, dev_tx_last, dev_rx_ready;
  logic [31:0] dev_tx_data;
  logic        dev_tx_ready = 1'b0;
  logic        dev_rx_valid = 1'b0;
  logic [31:0] dev_rx_data = '0;
  logic        dev_rx_last = 1'b0;
  logic        dev_cond = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] mem [0:1023];
  logic [31:0] tx_log [0:15];
  logic        tx_lastlog [0:15];
  int          tx_n = 0;
  int          tx_ctr = 0;
  logic [31:0] rx_words [0:15];
  logic        rx_lastf [0:15];
  int          rx_n = 0;
  int          rx_idx = 0;
  logic        rx_pend = 1'b0;
  int          irq_rises = 0;
  int          irq_cycles = 0;
  logic        irq_prev = 1'b0;

  localparam logic [31:0] MARK = 32'hFEED_F00D;

  always #2.5 clk = ~clk;

  dma_desc_chan i_dma_desc_chan (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .active(active), .dead(dead),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dev_key(dev_key), .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data),
    .dev_tx_last(dev_tx_last), .dev_tx_ready(dev_tx_ready),
    .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data),
    .dev_rx_last(dev_rx_last), .dev_rx_ready(dev_rx_ready),
    .dev_cond(dev_cond), .irq(irq)
  );

  // Memory, stream and interrupt models, all driven away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
        else mem_rdata = mem[mem_addr[11:2]];
      end else begin
        mem_ack = 1'b0;
      end
      tx_ctr++;
      dev_tx_ready = (tx_ctr % 3) != 2;
      if (dev_tx_valid && dev_tx_ready && tx_n < 16) begin
        tx_log[tx_n] = dev_tx_data;
        tx_lastlog[tx_n] = dev_tx_last;
        tx_n++;
      end
      if (rx_pend) rx_idx++;
      dev_rx_valid = rx_idx < rx_n;
      dev_rx_data  = (rx_idx < rx_n) ? rx_words[rx_idx] : 32'h0;
      dev_rx_last  = (rx_idx < rx_n) ? rx_lastf[rx_idx] : 1'b0;
      rx_pend = dev_rx_valid && dev_rx_ready;
      if (irq) irq_cycles++;
      if (irq && !irq_prev) irq_rises++;
      irq_prev = irq;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] w0(input logic [3:0] op, input logic [2:0] key,
                                     input logic [1:0] ic, input logic [1:0] bc,
                                     input logic [1:0] wc, input logic [15:0] cnt);
    return {op, 1'b0, key, 2'b00, ic, bc, wc, cnt};
  endfunction

  task automatic put_desc(input logic [31:0] a, input logic [31:0] word0,
                          input logic [31:0] daddr, input logic [31:0] w2);
    mem[a[11:2]]     = word0;
    mem[a[11:2] + 1] = daddr;
    mem[a[11:2] + 2] = w2;
    mem[a[11:2] + 3] = MARK;
  endtask

  task automatic run(input logic [31:0] a);
    int k;
    @(negedge clk);
    start_addr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (active && k < 20000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic t_reset;
    chk("R1 active", {31'b0, active}, 32'd0);
    chk("R1 dead", {31'b0, dead}, 32'd0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 tx_valid/rx_ready", {30'b0, dev_tx_valid, dev_rx_ready}, 32'd0);
  endtask

  task automatic t_output;
    dev_cond = 1'b0;
    tx_n = 0;
    mem[12'h800 >> 2] = 32'h1111_0000;
    mem[12'h804 >> 2] = 32'h1111_0001;
    mem[12'h900 >> 2] = 32'h2222_0000;
    mem[12'h904 >> 2] = 32'h2222_0001;
    put_desc(32'h100, w0(4'd0, 3'd1, 2'd0, 2'd0, 2'd0, 16'd8), 32'h800, 32'h0);
    put_desc(32'h110, w0(4'd1, 3'd1, 2'd0, 2'd0, 2'd0, 16'd6), 32'h900, 32'h0);
    put_desc(32'h120, w0(4'd7, 3'd0, 2'd0, 2'd0, 2'd0, 16'd0), 32'h0, 32'h0);
    run(32'h100);
    chk("R3 beat count", tx_n, 32'd4);
    chk("R3 word0", tx_log[0], 32'h1111_0000);
    chk("R3 word1", tx_log[1], 32'h1111_0001);
    chk("R3 word2", tx_log[2], 32'h2222_0000);
    chk("R3 word3", tx_log[3], 32'h2222_0001);
    chk("R3 last flags", {28'b0, tx_lastlog[0], tx_lastlog[1], tx_lastlog[2], tx_lastlog[3]}, 32'h1);
    chk("R5 writeback out-more", mem[12'h10C >> 2], 32'h8000_0000);
    chk("R5 writeback out-last", mem[12'h11C >> 2], 32'h8000_0000);
    chk("R11 stop no writeback", mem[12'h12C >> 2], MARK);
    chk("R11 halted not dead", {30'b0, active, dead}, 32'd0);
  endtask

  task automatic t_input;
    dev_cond = 1'b0;
    mem[12'hA48 >> 2] = 32'h0;
    rx_words[0] = 32'hAAAA_0001; rx_lastf[0] = 1'b1;
    rx_words[1] = 32'hAAAA_0002; rx_lastf[1] = 1'b0;
    rx_words[2] = 32'hBBBB_0001; rx_lastf[2] = 1'b0;
    rx_words[3] = 32'hBBBB_0002; rx_lastf[3] = 1'b1;
    rx_idx = 0;
    rx_n = 4;
    put_desc(32'h140, w0(4'd2, 3'd2, 2'd0, 2'd0, 2'd0, 16'd8), 32'hA00, 32'h0);
    put_desc(32'h150, w0(4'd3, 3'd2, 2'd0, 2'd0, 2'd0, 16'd16), 32'hA40, 32'h0);
    put_desc(32'h160, w0(4'd7, 3'd0, 2'd0, 2'd0, 2'd0, 16'd0), 32'h0, 32'h0);
    run(32'h140);
    rx_n = 0;
    chk("R4 in-more word0 (last ignored)", mem[12'hA00 >> 2], 32'hAAAA_0001);
    chk("R4 in-more word1", mem[12'hA04 >> 2], 32'hAAAA_0002);
    chk("R4 in-last word0", mem[12'hA40 >> 2], 32'hBBBB_0001);
    chk("R4 in-last word1", mem[12'hA44 >> 2], 32'hBBBB_0002);
    chk("R4 early end no third write", mem[12'hA48 >> 2], 32'h0);
    chk("R5 in-more residual", mem[12'h14C >> 2], 32'h8000_0000);
    chk("R4 in-last residual 8", mem[12'h15C >> 2], 32'h8000_0008);
  endtask

  task automatic t_branch_irq;
    int r0, c0;
    dev_cond = 1'b1;
    r0 = irq_rises;
    c0 = irq_cycles;
    put_desc(32'h200, w0(4'd6, 3'd0, 2'd1, 2'd1, 2'd0, 16'd5), 32'h0, 32'h300);
    put_desc(32'h210, w0(4'd6, 3'd0, 2'd0, 2'd0, 2'd0, 16'd0), 32'h0, 32'h0);
    put_desc(32'h300, w0(4'd6, 3'd0, 2'd2, 2'd2, 2'd0, 16'd0), 32'h0, 32'h200);
    put_desc(32'h310, w0(4'd7, 3'd0, 2'd0, 2'd0, 2'd0, 16'd0), 32'h0, 32'h0);
    run(32'h200);
    chk("R7/R8 nop status taken", mem[12'h20C >> 2], 32'h8003_0005);
    chk("R8 fall-through skipped", mem[12'h21C >> 2], MARK);
    chk("R8 not-taken status", mem[12'h30C >> 2], 32'h8001_0000);
    chk("R8 stop reached", mem[12'h31C >> 2], MARK);
    chk("R9 irq count", irq_rises - r0, 32'd1);
    chk("R9 irq width", irq_cycles - c0, 32'd1);
    dev_cond = 1'b0;
  endtask

  task automatic t_wait;
    dev_cond = 1'b1;
    put_desc(32'h400, w0(4'd6, 3'd0, 2'd0, 2'd0, 2'd3, 16'd0), 32'h0, 32'h0);
    put_desc(32'h410, w0(4'd6, 3'd0, 2'd0, 2'd0, 2'd0, 16'd3), 32'h0, 32'h0);
    put_desc(32'h420, w0(4'd7, 3'd0, 2'd0, 2'd0, 2'd0, 16'd0), 32'h0, 32'h0);
    @(negedge clk);
    start_addr = 32'h400;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    chk("R10 first written", mem[12'h40C >> 2], 32'h8001_0000);
    chk("R10 held before next", mem[12'h41C >> 2], MARK);
    chk("R10 still active", {31'b0, active}, 32'd1);
    dev_cond = 1'b0;
    run_wait_idle();
    chk("R10 resumes", mem[12'h41C >> 2], 32'h8000_0003);
  endtask

  task automatic run_wait_idle;
    int k;
    k = 0;
    while (active && k < 20000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic t_quad;
    dev_cond = 1'b0;
    mem[12'hC00 >> 2] = 32'h0;
    mem[12'hC40 >> 2] = 32'h1234_5678;
    put_desc(32'h500, w0(4'd4, 3'd6, 2'd0, 2'd0, 2'd0, 16'd4), 32'hC00, 32'hDEAD_BEEF);
    put_desc(32'h510, w0(4'd5, 3'd6, 2'd0, 2'd0, 2'd0, 16'd4), 32'hC40, 32'h0000_0600);
    put_desc(32'h520, w0(4'd7, 3'd0, 2'd0, 2'd0, 2'd0, 16'd0), 32'h0, 32'h0);
    run(32'h500);
    chk("R6 store-quad", mem[12'hC00 >> 2], 32'hDEAD_BEEF);
    chk("R6 load-quad into word2", mem[12'h518 >> 2], 32'h1234_5678);
    chk("R7 quad residual store", mem[12'h50C >> 2], 32'h8000_0004);
    chk("R7 quad residual load", mem[12'h51C >> 2], 32'h8000_0004);
  endtask

  task automatic t_dead;
    dev_cond = 1'b0;
    put_desc(32'h600, w0(4'd6, 3'd4, 2'd0, 2'd0, 2'd0, 16'd0), 32'h0, 32'h0);
    run(32'h600);
    chk("R12 reserved key dead", {30'b0, active, dead}, 32'd1);
    chk("R12 reserved key no writeback", mem[12'h60C >> 2], MARK);
    put_desc(32'h700, w0(4'd6, 3'd0, 2'd0, 2'd0, 2'd0, 16'h8001), 32'h0, 32'h0);
    run(32'h700);
    chk("R12 oversize count dead", {30'b0, active, dead}, 32'd1);
    chk("R12 oversize no writeback", mem[12'h70C >> 2], MARK);
    put_desc(32'h740, w0(4'd9, 3'd0, 2'd0, 2'd0, 2'd0, 16'd0), 32'h0, 32'h0);
    run(32'h740);
    chk("R12 bad opcode dead", {30'b0, active, dead}, 32'd1);
    put_desc(32'h780, w0(4'd6, 3'd0, 2'd0, 2'd0, 2'd0, 16'h8000), 32'h0, 32'h0);
    put_desc(32'h790, w0(4'd7, 3'd0, 2'd0, 2'd0, 2'd0, 16'd0), 32'h0, 32'h0);
    run(32'h780);
    chk("R12 max count accepted, dead cleared", {30'b0, active, dead}, 32'd0);
    chk("R12 max count writeback", mem[12'h78C >> 2], 32'h8000_8000);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_output();
    t_input();
    t_branch_irq();
    t_wait();
    t_quad();
    t_dead();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule